// File: doc/BRIEF.md
# Receive Frame Queue with Word Read-Out

This block accepts received Ethernet frames as a byte stream and stores each one as a framed record in a ring of packet slots. A record starts with a two-byte length equal to the payload size plus 6. The payload follows, then a 4-byte CRC32 of the payload that the block computes itself as the bytes arrive. Software drains the queue through a small register window. Each read of the data register returns the next four record bytes as one little-endian word. When a record is used up, the read side moves to the next slot and the packet count drops by one.

A status register holds three sticky event bits: frame stored, read underflow and frame dropped. A mask register selects which of these bits raise the interrupt output. A control register holds the receive-enable bit and a self-clearing queue-reset bit. Frames are dropped in three cases: while reception is disabled, when every slot is full, and when the record would not fit in a slot.

Register word addresses on `bus_addr`: 0 status (read) and status clear (write), 1 mask, 2 control, 3 data (read only), 4 packet count (read only). Other addresses read as zero.

Top module: `rx_queue`

## Requirements
- R1: After reset, status reads 0, mask reads 7, control reads 0, the packet count reads 0 and `irq` is low.
- R2: While control bit 0 (receive enable) is clear, incoming frames are discarded: the packet count stays unchanged and no status bit is set.
- R3: The first two bytes of a stored record are its length, equal to the payload byte count plus 6, low byte first. The payload bytes follow from record byte 2 onward, in arrival order.
- R4: Directly after the payload, the record holds the CRC32 of the payload, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, starts from 0xFFFFFFFF and is inverted at the end.
- R5: Bytes of the last data word that lie past the record length read as zero.
- R6: A data read (address 3) returns record bytes k..k+3 as bits 7:0 up to 31:24. When the word reaches or passes the record length, the next read starts the next slot and the packet count falls by one.
- R7: The queue holds at most SLOTS records (31 by default), and the read slot wraps from SLOTS-1 to 0. A frame that starts while all slots are full is discarded and sets status bit 2.
- R8: A payload of up to SLOT_BYTES-6 bytes (58 by default) is stored. A longer frame is discarded as a whole and sets status bit 2.
- R9: A data read while the count is 0 returns 0, sets status bit 1 and leaves the count at 0.
- R10: Storing a frame sets status bit 0. Writing to address 0 clears each status bit whose write-data bit is 1. `irq` is high exactly when status AND mask is non-zero.
- R11: Writing control with bit 4 set empties the queue (count 0, read position at slot 0). A frame in progress at that moment is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte present this cycle |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | This byte ends the frame |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (data reads advance the queue) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid in the cycle of the strobe |
| irq | output | 1 | Interrupt, high while any unmasked status bit is set |

## Verification
The hardest state to reach is a full ring whose read position is not at slot 0, because only that state shows the slot wrap and the full-queue drop together. The bench reaches it by first storing and draining 58 records, one for each payload length from 1 to 58, which leaves the read slot at 27. It then queues 31 records and offers a 32nd, so the stored records straddle the wrap from slot 30 to slot 0. A queue reset is also issued partway through a frame, with the frame's remaining bytes sent afterwards, to show that the interrupted frame never becomes a record.

// File: rtl/rx_queue.sv
module rx_queue #(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int SW   = $clog2(SLOTS);
  localparam int CW   = $clog2(SLOTS + 1);
  localparam int OW   = $clog2(SLOT_BYTES) + 1;
  localparam int MW   = $clog2(SLOTS * SLOT_BYTES);
  localparam int MAXP = SLOT_BYTES - 6;

  function automatic logic [MW-1:0] idx(input int s, input int o);
    return MW'(s * SLOT_BYTES + o);
  endfunction

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ (((r[0] ^ d[i]) == 1'b1) ? 32'hEDB88320 : 32'h0);
    return r;
  endfunction

  logic [7:0]    mem [SLOTS*SLOT_BYTES];
  logic [SW-1:0] rd_slot, wr_slot;
  logic [CW-1:0] count;
  logic [OW-1:0] rd_off, nbytes;
  logic          busy, drop;
  logic [31:0]   crc;
  logic [2:0]    sts, mask;
  logic          rx_en;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:5], bus_wdata[3]};

  // write side
  logic [SW:0]   slot_sum;
  logic [SW-1:0] new_slot, cur_slot;
  logic          full, first, cur_drop, over, keep, commit;
  logic [OW-1:0] cur_n;
  logic [31:0]   crc_nx, crc_fin;
  logic [15:0]   rec_len_wr;

  assign slot_sum   = {1'b0, rd_slot} + (SW+1)'(count);
  assign new_slot   = (slot_sum >= (SW+1)'(SLOTS)) ? SW'(slot_sum - (SW+1)'(SLOTS)) : SW'(slot_sum);
  assign full       = (count == CW'(SLOTS));
  assign first      = !busy;
  assign cur_slot   = first ? new_slot : wr_slot;
  assign cur_drop   = first ? (!rx_en || full) : drop;
  assign cur_n      = first ? '0 : nbytes;
  assign over       = (cur_n == OW'(MAXP));
  assign keep       = in_valid && !cur_drop && !over;
  assign crc_nx     = crc_step(first ? 32'hFFFFFFFF : crc, in_data);
  assign crc_fin    = ~crc_nx;
  assign commit     = keep && in_last;
  assign rec_len_wr = 16'(cur_n) + 16'd7;

  // register side
  logic fifo_rst, data_rd, pop_ok, last_word, pop, uflow, dropped;
  assign fifo_rst = bus_wr && bus_addr == 3'd2 && bus_wdata[4];
  assign data_rd  = bus_rd && bus_addr == 3'd3;
  assign pop_ok   = (count != '0);
  assign uflow    = data_rd && !pop_ok;
  assign dropped  = in_valid && ((first && rx_en && full) || (!cur_drop && over));

  // read side
  logic [15:0] rec_len;
  logic [31:0] word;
  assign rec_len   = {mem[idx(int'(rd_slot), 1)], mem[idx(int'(rd_slot), 0)]};
  assign last_word = (int'(rd_off) + 4 >= int'(rec_len));
  assign pop       = data_rd && pop_ok && last_word;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      int o;
      o = int'(rd_off) + i;
      word[8*i +: 8] = (o < int'(rec_len)) ? mem[idx(int'(rd_slot), o)] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (keep) begin
      mem[idx(int'(cur_slot), int'(cur_n) + 2)] <= in_data;
      if (in_last) begin
        mem[idx(int'(cur_slot), 0)] <= rec_len_wr[7:0];
        mem[idx(int'(cur_slot), 1)] <= rec_len_wr[15:8];
        for (int i = 0; i < 4; i++)
          mem[idx(int'(cur_slot), int'(cur_n) + 3 + i)] <= crc_fin[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      drop    <= 1'b0;
      nbytes  <= '0;
      crc     <= '1;
      wr_slot <= '0;
    end else begin
      if (in_valid) begin
        busy    <= !in_last;
        drop    <= cur_drop || over;
        nbytes  <= cur_n + OW'(1);
        crc     <= crc_nx;
        wr_slot <= cur_slot;
      end
      if (fifo_rst) drop <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_slot <= '0;
      rd_off  <= '0;
      count   <= '0;
    end else if (fifo_rst) begin
      rd_slot <= '0;
      rd_off  <= '0;
      count   <= '0;
    end else begin
      if (data_rd && pop_ok) begin
        if (last_word) begin
          rd_off  <= '0;
          rd_slot <= (rd_slot == SW'(SLOTS - 1)) ? '0 : rd_slot + SW'(1);
        end else begin
          rd_off <= rd_off + OW'(4);
        end
      end
      count <= count + CW'(commit) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts   <= '0;
      mask  <= 3'b111;
      rx_en <= 1'b0;
    end else begin
      sts <= (sts & ~((bus_wr && bus_addr == 3'd0) ? bus_wdata[2:0] : 3'b000))
             | {dropped, uflow, commit};
      if (bus_wr && bus_addr == 3'd1) mask  <= bus_wdata[2:0];
      if (bus_wr && bus_addr == 3'd2) rx_en <= bus_wdata[0];
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {29'b0, sts};
      3'd1:    bus_rdata = {29'b0, mask};
      3'd2:    bus_rdata = {31'b0, rx_en};
      3'd3:    bus_rdata = pop_ok ? word : 32'h0;
      3'd4:    bus_rdata = 32'(count);
      default: bus_rdata = 32'h0;
    endcase
  end

  assign irq = |(sts & mask);
endmodule

// File: rtl/rx_queue_chk.sv
module rx_queue_chk #(
  parameter int SLOTS = 31
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [2:0]                 bus_addr,
  input logic                       rst_bit,
  input logic [$clog2(SLOTS+1)-1:0] count,
  input logic [$clog2(SLOTS)-1:0]   rd_slot,
  input logic [2:0]                 sts,
  input logic                       irq
);
  localparam int CW = $clog2(SLOTS + 1);
  localparam int SW = $clog2(SLOTS);

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(SLOTS));

  assert_slot_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_slot <= SW'(SLOTS - 1));

  assert_underflow_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd3 && count == '0) |=> sts[1]);

  assert_fifo_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd2 && rst_bit) |=> (count == '0 && rd_slot == '0));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 3'd2 && rst_bit) |=>
      (count == $past(count) || count == $past(count) + CW'(1) || count + CW'(1) == $past(count)));

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts == 3'b000) |-> !irq);
endmodule

bind rx_queue rx_queue_chk #(.SLOTS(SLOTS)) chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .rst_bit(bus_wdata[4]), .count(count), .rd_slot(rd_slot), .sts(sts), .irq(irq)
);

// File: tb/rx_queue_test.sv
module rx_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 31;
  localparam int SLOT_BYTES = 64;
  localparam int MAXP = SLOT_BYTES - 6;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;

  rx_queue #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int seed, input int i);
    return 8'((seed * 7 + i * 13 + 1) & 255);
  endfunction

  function automatic logic [31:0] crc_of(input int seed, input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = pay(seed, i);
      for (int b = 0; b < 8; b++)
        c = (c >> 1) ^ ((c[0] ^ d[b]) ? 32'hEDB88320 : 32'h0);
    end
    return ~c;
  endfunction

  function automatic logic [7:0] rec_byte(input int seed, input int n, input int k, input logic [31:0] c);
    int len = n + 6;
    if (k == 0) return 8'(len & 255);
    if (k == 1) return 8'(len >> 8);
    if (k < 2 + n) return pay(seed, k - 2);
    if (k < len) return c[8*(k-2-n) +: 8];
    return 8'h00;
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic push(input logic [7:0] b, input logic last);
    @(negedge clk); in_valid = 1; in_data = b; in_last = last;
    @(posedge clk); #1 in_valid = 0; in_last = 0;
  endtask

  task automatic send(input int seed, input int n);
    for (int i = 0; i < n; i++) push(pay(seed, i), i == n - 1);
  endtask

  task automatic drain(input int seed, input int n, input string rq);
    logic [31:0] c = crc_of(seed, n);
    int words = (n + 6 + 3) / 4;
    for (int w = 0; w < words; w++) begin
      logic [31:0] got, exp;
      for (int b = 0; b < 4; b++) exp[8*b +: 8] = rec_byte(seed, n, 4*w + b, c);
      reg_read(3'd3, got);
      chk(rq, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    reg_read(3'd0, v); chk("R1 status", v, 0);
    reg_read(3'd1, v); chk("R1 mask", v, 7);
    reg_read(3'd2, v); chk("R1 control", v, 0);
    reg_read(3'd4, v); chk("R1 count", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 disabled receive
    send(99, 10);
    reg_read(3'd4, v); chk("R2 count", v, 0);
    reg_read(3'd0, v); chk("R2 status", v, 0);

    reg_write(3'd2, 32'h1);
    // R3 R4 R5 R6 R8 sweep of every storable payload length
    for (int n = 1; n <= MAXP; n++) begin
      send(n, n);
      reg_read(3'd4, v); chk("R6 count after store", v, 1);
      reg_read(3'd0, v); chk("R10 rx bit", v, 1);
      chk("R10 irq", {31'b0, irq}, 1);
      drain(n, n, (n == MAXP) ? "R8 max payload record" : "R3 R4 R5 record word");
      reg_read(3'd4, v); chk("R6 count after drain", v, 0);
      reg_write(3'd0, 32'h1);
    end
    reg_read(3'd0, v); chk("R10 w1c", v, 0);
    chk("R10 irq clear", {31'b0, irq}, 0);

    // R7 fill the ring across the wrap (read slot starts at 58 mod 31)
    for (int k = 0; k < SLOTS; k++) send(200 + k, 1 + (k * 5) % MAXP);
    reg_read(3'd4, v); chk("R7 count full", v, SLOTS);
    send(77, 4);
    reg_read(3'd4, v); chk("R7 count after extra", v, SLOTS);
    reg_read(3'd0, v); chk("R7 drop bit", v, 5);
    for (int k = 0; k < SLOTS; k++) drain(200 + k, 1 + (k * 5) % MAXP, "R7 wrapped record");
    reg_read(3'd4, v); chk("R7 count empty", v, 0);
    reg_write(3'd0, 32'h7);

    // R8 oversize frame
    send(5, MAXP + 1);
    reg_read(3'd4, v); chk("R8 oversize count", v, 0);
    reg_read(3'd0, v); chk("R8 oversize drop bit", v, 4);
    reg_write(3'd0, 32'h7);

    // R9 underflow
    reg_read(3'd3, v); chk("R9 data", v, 0);
    reg_read(3'd0, v); chk("R9 bit", v, 2);
    reg_read(3'd4, v); chk("R9 count", v, 0);
    reg_write(3'd0, 32'h7);

    // R10 mask
    send(3, 7);
    chk("R10 irq on", {31'b0, irq}, 1);
    reg_write(3'd1, 32'h0);
    chk("R10 masked irq", {31'b0, irq}, 0);
    reg_write(3'd1, 32'h7);

    // R11 queue reset, including a frame cut in half
    send(4, 9);
    reg_write(3'd2, 32'h11);
    reg_read(3'd4, v); chk("R11 count", v, 0);
    reg_read(3'd3, v); chk("R11 empty data", v, 0);
    for (int i = 0; i < 3; i++) push(pay(8, i), 1'b0);
    reg_write(3'd2, 32'h11);
    push(8'hAA, 1'b0); push(8'hBB, 1'b1);
    reg_read(3'd4, v); chk("R11 aborted frame", v, 0);
    send(11, 13);
    reg_read(3'd4, v); chk("R11 count after restart", v, 1);
    drain(11, 13, "R11 record after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule